// File: doc/BRIEF.md
# Time-Slice Serial Framer and Deframer

This block moves one front-end time-slice record over a single serial data line, one bit per clock. A record holds a hit pattern of 64 channel bits and a 24-bit timestamp, 11 bytes in all. The transmit side takes a record with a valid/ready handshake and sends it as a fixed frame of 121 bits. Each byte becomes an 11-bit group: a low start bit, the eight data bits, a parity bit and a high stop bit. Between frames the line rests high, and an idle flag reports that no frame is in flight. With the nominal 100 ns bit clock, one frame occupies 12.1 us.

The transmitter can take a new record during the cycle that carries the last bit of the current frame. That record then follows with no gap, so a busy link carries one frame after another. A matching receiver watches a serial input for the first low bit and takes apart the eleven groups. It then either delivers the record or reports a parity or framing fault for that frame, and after that it hunts for the next start. In the top level the receiver's input is a separate port, so the same block can close a loop or sit at the far end of a link.

Top module: `slice_link`

## Requirements
- R1: Each accepted record produces exactly 121 bit periods of frame on `ser_out`, beginning in the cycle after the handshake; throughout those cycles `line_idle` is 0.
- R2: The frame is 11 back-to-back groups of 11 bits. Within a group, position 0 is a start bit of value 0 and position 10 is a stop bit of value 1. Frame bit index i falls in group i/11 at position i%11.
- R3: Group positions 1 to 8 carry one byte, least significant bit first. Groups 0 to 7 carry `tx_hits` bytes in ascending order, so `tx_hits[7:0]` comes first. Groups 8 to 10 carry `tx_stamp`, least significant byte first.
- R4: Group position 9 is an odd parity bit: the data byte and this bit together hold an odd number of ones.
- R5: After reset, and whenever no frame is in flight, `ser_out` is 1, `line_idle` is 1 and `tx_ready` is 1. After reset the receiver outputs are all 0.
- R6: `tx_ready` is 1 in the cycle that carries bit 120. A record accepted in that cycle starts its frame in the very next cycle, with no idle bit between the frames.
- R7: `tx_ready` is 0 during bits 0 to 119 of a frame. Changes on `tx_hits`/`tx_stamp` during that time do not alter the frame on the line.
- R8: When a frame arrives intact on `ser_in`, `rx_valid` is high for exactly one cycle, beginning at the clock edge that samples the last stop bit. At the same time `rx_hits`/`rx_stamp` take the sent record.
- R9: A parity mismatch in any group raises `rx_parity_err` for one cycle at the end of that frame instead of `rx_valid`. `rx_hits`/`rx_stamp` keep the previous good record.
- R10: A start bit read as 1 (groups 1 to 10) or a stop bit read as 0 raises `rx_frame_err` for one cycle at the end of that frame instead of `rx_valid`.
- R11: After ending a frame, good or flagged, the receiver waits for the next 0 on the line. A frame that follows with no gap is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_hits | input | 64 | Hit pattern of the record to send, channel n at bit n |
| tx_stamp | input | 24 | Timestamp of the record to send |
| tx_valid | input | 1 | A record is offered |
| tx_ready | output | 1 | The offered record is taken at this edge when `tx_valid` is high |
| ser_out | output | 1 | Serial frame output, high when idle |
| line_idle | output | 1 | High when no frame is being sent |
| ser_in | input | 1 | Serial input to the receiver |
| rx_hits | output | 64 | Hit pattern of the last good frame |
| rx_stamp | output | 24 | Timestamp of the last good frame |
| rx_valid | output | 1 | One-cycle pulse: an intact frame was received |
| rx_parity_err | output | 1 | One-cycle pulse: the frame just ended had a parity fault |
| rx_frame_err | output | 1 | One-cycle pulse: the frame just ended had a start or stop fault |

## Verification
The bench builds the block with its default parameters: 8 hit bytes, 3 stamp bytes, 8-bit bytes and odd parity. At these values the frame is the full 121 bits and group ordering across the hit/stamp boundary can be observed. A single set bit is walked through all 88 record positions, so every data slot in every group is checked in isolation, along with parity for both even and odd byte weights. The bench flips chosen bits between `ser_out` and `ser_in` to corrupt a data bit, a parity bit, a start bit and a stop bit. It then places faulted frames directly before good ones to check that the receiver keeps its alignment.

// File: rtl/slice_link_pkg.sv
package slice_link_pkg;

   // start, parity and stop bit around every payload byte
   localparam int unsigned CTRL_BITS = 3;

   typedef enum logic {
      RX_HUNT = 1'b0,
      RX_BODY = 1'b1
   } rx_state_e;

   // counter width able to hold values 0..n
   function automatic int unsigned ctr_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/slice_frame_pack.sv
module slice_frame_pack
   import slice_link_pkg::*;
#(
   parameter int HIT_BYTES  = 8,
   parameter int TS_BYTES   = 3,
   parameter int BYTE_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic [HIT_BYTES*BYTE_W-1:0]                            hits,
   input  logic [TS_BYTES*BYTE_W-1:0]                             stamp,
   output logic [(HIT_BYTES+TS_BYTES)*(BYTE_W+CTRL_BITS)-1:0]     frame
);
   localparam int NB    = HIT_BYTES + TS_BYTES;
   localparam int GW    = BYTE_W + CTRL_BITS;
   localparam int REC_W = NB * BYTE_W;

   // hit bytes occupy the low byte slots, so they lead on the line
   logic [REC_W-1:0] rec;
   assign rec = {stamp, hits};

   for (genvar g = 0; g < NB; g++) begin : g_grp
      logic [BYTE_W-1:0] d;
      logic              pb;
      assign d = rec[g*BYTE_W +: BYTE_W];
      if (ODD_PARITY) begin : g_odd
         assign pb = ~^d;
      end else begin : g_even
         assign pb = ^d;
      end
      assign frame[g*GW]              = 1'b0;
      assign frame[g*GW+1 +: BYTE_W]  = d;
      assign frame[g*GW+BYTE_W+1]     = pb;
      assign frame[g*GW+BYTE_W+2]     = 1'b1;
   end

endmodule

// File: rtl/slice_ser_tx.sv
module slice_ser_tx
   import slice_link_pkg::*;
#(
   parameter int FRAME_W = 121
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] frame,
   input  logic               in_valid,
   output logic               in_ready,
   output logic               ser_out,
   output logic               line_idle
);
   localparam int CW = ctr_w(FRAME_W);

   logic [FRAME_W-1:0] sreg;
   logic [CW-1:0]      cnt;
   logic               busy;
   logic               last;
   logic               take;

   assign last      = busy && (cnt == CW'(FRAME_W - 1));
   assign in_ready  = !busy || last;
   assign take      = in_valid && in_ready;
   assign ser_out   = busy ? sreg[0] : 1'b1;
   assign line_idle = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '1;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (take) begin
         sreg <= frame;
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            cnt  <= cnt + 1'b1;
         end
      end
   end

   // R2
   lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !ser_out);
   // R5
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_idle |-> ser_out);
   // R1
   span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (!line_idle && !in_ready || last));
   // R6
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !in_valid) |=> line_idle);

endmodule

// File: rtl/slice_ser_rx.sv
module slice_ser_rx
   import slice_link_pkg::*;
#(
   parameter int NBYTES     = 11,
   parameter int BYTE_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_in,
   output logic [NBYTES*BYTE_W-1:0] rec_q,
   output logic                     rec_valid,
   output logic                     par_err,
   output logic                     frm_err
);
   localparam int   GW        = BYTE_W + CTRL_BITS;
   localparam int   PW        = ctr_w(GW);
   localparam int   GRW       = ctr_w(NBYTES);
   localparam int   REC_W     = NBYTES * BYTE_W;
   localparam logic PAR_SENSE = ODD_PARITY;

   rx_state_e        state;
   logic [PW-1:0]    pos;
   logic [GRW-1:0]   grp;
   logic [REC_W-1:0] acc;
   logic             run_par, bad_par, bad_frm;

   logic at_start, at_data, at_par, at_stop, last_grp;
   logic par_bad_now, frm_bad_now, fin_par, fin_frm;

   assign at_start    = (pos == '0);
   assign at_data     = (pos != '0) && (pos <= PW'(BYTE_W));
   assign at_par      = (pos == PW'(BYTE_W + 1));
   assign at_stop     = (pos == PW'(GW - 1));
   assign last_grp    = (grp == GRW'(NBYTES - 1));
   assign par_bad_now = at_par && ((run_par ^ ser_in) != PAR_SENSE);
   assign frm_bad_now = (at_start && ser_in) || (at_stop && !ser_in);
   assign fin_par     = bad_par | par_bad_now;
   assign fin_frm     = bad_frm | frm_bad_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_HUNT;
         pos       <= '0;
         grp       <= '0;
         acc       <= '0;
         rec_q     <= '0;
         run_par   <= 1'b0;
         bad_par   <= 1'b0;
         bad_frm   <= 1'b0;
         rec_valid <= 1'b0;
         par_err   <= 1'b0;
         frm_err   <= 1'b0;
      end else begin
         rec_valid <= 1'b0;
         par_err   <= 1'b0;
         frm_err   <= 1'b0;
         case (state)
            RX_HUNT: begin
               if (!ser_in) begin
                  // this low bit is the start bit of group 0
                  state   <= RX_BODY;
                  pos     <= PW'(1);
                  grp     <= '0;
                  run_par <= 1'b0;
                  bad_par <= 1'b0;
                  bad_frm <= 1'b0;
               end
            end
            RX_BODY: begin
               bad_par <= fin_par;
               bad_frm <= fin_frm;
               if (at_start) run_par <= 1'b0;
               if (at_data) begin
                  acc     <= {ser_in, acc[REC_W-1:1]};
                  run_par <= run_par ^ ser_in;
               end
               if (at_stop) begin
                  pos <= '0;
                  if (last_grp) begin
                     state <= RX_HUNT;
                     if (!fin_par && !fin_frm) begin
                        rec_q     <= acc;
                        rec_valid <= 1'b1;
                     end else begin
                        par_err <= fin_par;
                        frm_err <= fin_frm;
                     end
                  end else begin
                     grp <= grp + 1'b1;
                  end
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            default: state <= RX_HUNT;
         endcase
      end
   end

   // R8
   valid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> !rec_valid);
   // R9
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !(par_err || frm_err));
   // R11
   verdict_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid || par_err || frm_err) |-> (state == RX_HUNT));
   // R10
   frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err || frm_err) |-> $stable(rec_q));

endmodule

// File: rtl/slice_link.sv
module slice_link
   import slice_link_pkg::*;
#(
   parameter int HIT_BYTES  = 8,
   parameter int TS_BYTES   = 3,
   parameter int BYTE_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [HIT_BYTES*BYTE_W-1:0]   tx_hits,
   input  logic [TS_BYTES*BYTE_W-1:0]    tx_stamp,
   input  logic                          tx_valid,
   output logic                          tx_ready,
   output logic                          ser_out,
   output logic                          line_idle,
   input  logic                          ser_in,
   output logic [HIT_BYTES*BYTE_W-1:0]   rx_hits,
   output logic [TS_BYTES*BYTE_W-1:0]    rx_stamp,
   output logic                          rx_valid,
   output logic                          rx_parity_err,
   output logic                          rx_frame_err
);
   localparam int NB      = HIT_BYTES + TS_BYTES;
   localparam int HIT_W   = HIT_BYTES * BYTE_W;
   localparam int REC_W   = NB * BYTE_W;
   localparam int FRAME_W = NB * (BYTE_W + CTRL_BITS);

   if (HIT_BYTES < 1 || TS_BYTES < 1 || BYTE_W < 2) begin : g_bad_cfg
      $error("slice_link: need at least one hit byte, one stamp byte and BYTE_W >= 2");
   end

   logic [FRAME_W-1:0] frame;
   logic [REC_W-1:0]   rx_rec;

   slice_frame_pack #(
      .HIT_BYTES (HIT_BYTES),
      .TS_BYTES  (TS_BYTES),
      .BYTE_W    (BYTE_W),
      .ODD_PARITY(ODD_PARITY)
   ) u_pack (
      .hits (tx_hits),
      .stamp(tx_stamp),
      .frame(frame)
   );

   slice_ser_tx #(
      .FRAME_W(FRAME_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame    (frame),
      .in_valid (tx_valid),
      .in_ready (tx_ready),
      .ser_out  (ser_out),
      .line_idle(line_idle)
   );

   slice_ser_rx #(
      .NBYTES    (NB),
      .BYTE_W    (BYTE_W),
      .ODD_PARITY(ODD_PARITY)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_in   (ser_in),
      .rec_q    (rx_rec),
      .rec_valid(rx_valid),
      .par_err  (rx_parity_err),
      .frm_err  (rx_frame_err)
   );

   assign rx_hits  = rx_rec[HIT_W-1:0];
   assign rx_stamp = rx_rec[REC_W-1:HIT_W];

endmodule

// File: tb/slice_link_test.sv
module slice_link_test;
   localparam int NB = 11;
   localparam int GW = 11;
   localparam int FW = NB * GW;
   localparam int RW = NB * 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [RW-1:0] tx_rec;
   logic          tx_valid;
   logic          tx_ready, ser_out, line_idle, ser_in;
   logic [63:0]   rx_hits;
   logic [23:0]   rx_stamp;
   logic          rx_valid, rx_parity_err, rx_frame_err;
   logic          flip;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   assign ser_in = ser_out ^ flip;

   slice_link uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_hits      (tx_rec[63:0]),
      .tx_stamp     (tx_rec[87:64]),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .ser_out      (ser_out),
      .line_idle    (line_idle),
      .ser_in       (ser_in),
      .rx_hits      (rx_hits),
      .rx_stamp     (rx_stamp),
      .rx_valid     (rx_valid),
      .rx_parity_err(rx_parity_err),
      .rx_frame_err (rx_frame_err)
   );

   task automatic check(input bit ok, input string req,
                        input logic [RW-1:0] act, input logic [RW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_frame(input logic [RW-1:0] r);
      logic [FW-1:0] f;
      logic [7:0]    b;
      for (int g = 0; g < NB; g++) begin
         b = r[g*8 +: 8];
         f[g*GW] = 1'b0;
         for (int j = 0; j < 8; j++) f[g*GW+1+j] = b[j];
         f[g*GW+9]  = ~^b;
         f[g*GW+10] = 1'b1;
      end
      return f;
   endfunction

   logic [RW-1:0] last_good;

   // Called right after the edge that accepted rec.
   task automatic run_frame(input logic [RW-1:0] rec, input bit has_next,
                            input logic [RW-1:0] nxt, input int flip_at);
      logic [FW-1:0] f;
      int            pos;
      f = exp_frame(rec);
      for (int i = 0; i < FW; i++) begin
         @(negedge clk);
         if (i == 0) begin
            if (has_next) tx_rec = nxt;
            else tx_valid = 1'b0;
         end
         flip = (i == flip_at);
         pos = i % GW;
         if (pos == 0 || pos == GW - 1)
            check(ser_out == f[i], "R2 control bit", RW'(ser_out), RW'(f[i]));
         else if (pos == 9)
            check(ser_out == f[i], "R4 parity bit", RW'(ser_out), RW'(f[i]));
         else
            check(ser_out == f[i], "R3 data bit", RW'(ser_out), RW'(f[i]));
         check(line_idle == 1'b0, "R1 busy span", RW'(line_idle), '0);
         if (i == FW - 1)
            check(tx_ready == 1'b1, "R6 ready on last bit", RW'(tx_ready), RW'(1));
         else
            check(tx_ready == 1'b0, "R7 ready low mid-frame", RW'(tx_ready), '0);
         if (i >= 1)
            check(rx_valid == 1'b0, "R8 no early valid", RW'(rx_valid), '0);
      end
      @(posedge clk);
      #3;
      flip = 1'b0;
      if (flip_at < 0) begin
         check(rx_valid == 1'b1, "R8 valid pulse", RW'(rx_valid), RW'(1));
         check({rx_stamp, rx_hits} == rec, "R8 record", {rx_stamp, rx_hits}, rec);
         check(!rx_parity_err && !rx_frame_err, "R8 no fault",
               RW'({rx_parity_err, rx_frame_err}), '0);
         last_good = rec;
      end else begin
         pos = flip_at % GW;
         check(rx_valid == 1'b0, "R9 no valid on fault", RW'(rx_valid), '0);
         check({rx_stamp, rx_hits} == last_good, "R9 record kept",
               {rx_stamp, rx_hits}, last_good);
         if (pos == 0 || pos == GW - 1)
            check(rx_frame_err && !rx_parity_err, "R10 framing fault",
                  RW'({rx_parity_err, rx_frame_err}), RW'(1));
         else
            check(rx_parity_err && !rx_frame_err, "R9 parity fault",
                  RW'({rx_parity_err, rx_frame_err}), RW'(2));
      end
      if (has_next) begin
         check(line_idle == 1'b0 && ser_out == 1'b0, "R6 no gap",
               RW'({line_idle, ser_out}), '0);
      end else begin
         check(line_idle == 1'b1 && ser_out == 1'b1, "R1 frame ends",
               RW'({line_idle, ser_out}), RW'(3));
      end
   endtask

   task automatic start_frame(input logic [RW-1:0] rec);
      @(negedge clk);
      check(tx_ready == 1'b1 && line_idle == 1'b1, "R5 idle ready",
            RW'({tx_ready, line_idle}), RW'(3));
      tx_rec   = rec;
      tx_valid = 1'b1;
      @(posedge clk);
   endtask

   task automatic send(input logic [RW-1:0] rec, input int flip_at);
      start_frame(rec);
      run_frame(rec, 1'b0, '0, flip_at);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [RW-1:0] r;
      rst_n     = 1'b0;
      tx_valid  = 1'b0;
      tx_rec    = '0;
      flip      = 1'b0;
      last_good = '0;
      repeat (3) @(negedge clk);
      // R5 reset state
      check(ser_out == 1'b1, "R5 reset line", RW'(ser_out), RW'(1));
      check(line_idle == 1'b1, "R5 reset idle", RW'(line_idle), RW'(1));
      check(tx_ready == 1'b1, "R5 reset ready", RW'(tx_ready), RW'(1));
      check({rx_valid, rx_parity_err, rx_frame_err} == 3'b000, "R5 reset rx flags",
            RW'({rx_valid, rx_parity_err, rx_frame_err}), '0);
      check({rx_stamp, rx_hits} == '0, "R5 reset rx record", {rx_stamp, rx_hits}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send('0, -1);
      send('1, -1);
      // R3 distinct byte values reveal group order
      for (int g = 0; g < NB; g++) r[g*8 +: 8] = 8'h10 + 8'(g * 17);
      send(r, -1);
      // R3 R4 walking one through every record bit
      for (int i = 0; i < RW; i++) send(RW'(1) << i, -1);
      for (int i = 0; i < 12; i++) send({$urandom, $urandom, $urandom}, -1);

      // R5 idle line stays high between frames
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(ser_out == 1'b1 && line_idle == 1'b1, "R5 idle high",
               RW'({ser_out, line_idle}), RW'(3));
      end

      // R6 R7 back-to-back frames with the input changed mid-frame
      start_frame(88'h0123_4567_89AB_CDEF_0246_8A);
      run_frame(88'h0123_4567_89AB_CDEF_0246_8A, 1'b1, 88'hFEDC_BA98_7654_3210_1357_9B, -1);
      run_frame(88'hFEDC_BA98_7654_3210_1357_9B, 1'b1, 88'h5555_AAAA_5555_AAAA_5555_AA, -1);
      run_frame(88'h5555_AAAA_5555_AAAA_5555_AA, 1'b0, '0, -1);

      // R9 parity faults: data bit in group 3, parity bit in group 10
      send(88'hA5A5_A5A5_A5A5_A5A5_A5A5_A5, 3 * GW + 4);
      send(88'h1111_2222_3333_4444_5555_66, 10 * GW + 9);
      // R10 framing faults: stop of group 0, start of group 5
      send(88'h0F0F_0F0F_0F0F_0F0F_0F0F_0F, GW - 1);
      send(88'h7777_8888_9999_AAAA_BBBB_CC, 5 * GW);
      send(88'h0000_0000_0000_0000_0000_01, -1);

      // R11 faulted frames followed directly by good ones
      start_frame(88'hDEAD_BEEF_CAFE_F00D_1234_56);
      run_frame(88'hDEAD_BEEF_CAFE_F00D_1234_56, 1'b1, 88'h0BAD_F00D_4321_8765_ABCD_EF, 7 * GW + 10);
      run_frame(88'h0BAD_F00D_4321_8765_ABCD_EF, 1'b1, 88'h1357_2468_ACE0_BDF1_9753_86, -1);
      run_frame(88'h1357_2468_ACE0_BDF1_9753_86, 1'b1, 88'h2222_4444_6666_8888_AAAA_CC, 2 * GW + 2);
      run_frame(88'h2222_4444_6666_8888_AAAA_CC, 1'b0, '0, -1);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule